// File: doc/BRIEF.md
# Banked Local RAM ECC Monitor

This block sits on the read return path of a 128-bit local RAM. Every access is handled as four 32-bit lanes, or banks, numbered 0 to 3. Each lane carries its own 7 check bits and has its own single-error-correct, double-error-detect checker. A lane that is enabled on a read gets its single-bit error corrected, and the corrected data returns to the reader combinationally in the same cycle. A double-bit error in any enabled lane raises a fatal output in that same cycle, and that lane's data passes through uncorrected.

Single-bit detections are logged per bank. The first detection sets the bank's status flag and captures the access address in a compressed line form. Any later detection while the flag is still set only raises the bank's overflow flag, so the first error's address is kept. Software reads the logged state through a small register port. It clears banks one at a time through a write-only clear register. An interrupt output is raised while any status or overflow flag is set.

Top module: `lram_ecc_mon`

## Requirements
- R1: Each lane uses an extended Hamming code. Data bit i occupies the i-th position, counting from 1, that is not a power of two. Check bit j (j = 0..5) is the XOR of the data bits whose position has bit j set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5. A single flipped data bit in an enabled lane is corrected on `rd_data_o` in the same cycle.
- R2: A single flipped check bit in an enabled lane, including check bit 6, leaves the lane data unchanged. It still counts as a single-bit detection.
- R3: When `rd_valid_i` is high, a double-bit error in any enabled lane drives `fatal_o` high in the same cycle. That lane's data is output as received, and no status flag is set. `fatal_o` is low whenever `rd_valid_i` is low.
- R4: The first single-bit detection in bank n sets bit 8·n of the status register (address 0). It also captures `rd_addr_i` shifted right by 4 into the address register of bank n, at register address 4+n. The full address is rebuilt as (reg << 4) | (4·n). The captured value holds while the flag stays set.
- R5: A single-bit detection in bank n while its status flag is set sets bit n of the overflow register (address 1). It leaves the captured address unchanged.
- R6: Writing 1 to bit n of the clear register (address 2) clears bank n's status flag, overflow flag and captured address in the next cycle. Banks whose bits are written 0 keep their state. The clear register reads as 0.
- R7: If a clear of bank n and a new single-bit detection in bank n occur in the same cycle, the detection wins. The status flag ends set, the new address is captured, and the overflow flag ends clear.
- R8: `irq_o` is high exactly while any status or overflow flag is set. It therefore rises in the cycle after the read that caused the first detection.
- R9: A lane whose `rd_bank_en_i` bit is low, or any read with `rd_valid_i` low, sets no flag and raises no fatal. A disabled lane's data passes through uncorrected.
- R10: After reset, all status, overflow and address registers read 0 and `irq_o` is low.
- R11: Writes to register addresses other than 2 have no effect. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_valid_i | input | 1 | Read data valid |
| rd_bank_en_i | input | 4 | Per-lane check enable |
| rd_addr_i | input | 20 | Byte address of the 128-bit access |
| rd_data_i | input | 128 | Raw read data, lane n at bits 32n+31:32n |
| rd_chk_i | input | 28 | Check bits, lane n at bits 7n+6:7n |
| rd_data_o | output | 128 | Corrected read data |
| fatal_o | output | 1 | Double-bit error on the current read |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Any status or overflow flag set |

## Verification
A vector table drives clean reads, single flips on data bits at both lane edges and in the middle, and single flips on ordinary and overall check bits. It also drives double flips that span data only, data plus check, and check only. Each pattern is run against different lane-enable masks. This separates correction from detection, check-bit errors from data errors, and enabled lanes from disabled ones. Directed sequences then repeat errors in one bank to separate the first-error capture from overflow. They clear one bank while others hold state, collide a clear with a new error, and write to the read-only addresses.

// File: rtl/lram_ecc_pkg.sv
package lram_ecc_pkg;
  localparam int LANE_W = 32;
  localparam int HAM_W  = 6;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CW_W   = LANE_W + HAM_W;

  // Position (1-based) of data bit i among non-power-of-two positions
  function automatic int data_pos(input int i);
    int n;
    int p;
    n = 0;
    p = 0;
    for (int q = 1; q < 64; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == i) p = q;
        n++;
      end
    end
    return p;
  endfunction

  function automatic logic [CHK_W-1:0] ecc_gen(input logic [LANE_W-1:0] d);
    logic [CHK_W-1:0] c;
    logic [7:0]       pos;
    c = '0;
    for (int i = 0; i < LANE_W; i++) begin
      pos = 8'(data_pos(i));
      for (int j = 0; j < HAM_W; j++)
        if (pos[j]) c[j] = c[j] ^ d[i];
    end
    c[HAM_W] = ^{d, c[HAM_W-1:0]};
    return c;
  endfunction
endpackage

// File: rtl/lram_secded_dec.sv
module lram_secded_dec
  import lram_ecc_pkg::*;
(
  input  logic              en_i,
  input  logic [LANE_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [LANE_W-1:0] data_o,
  output logic              sb_o,
  output logic              db_o
);
  logic [CHK_W-1:0]  recalc;
  logic [HAM_W-1:0]  syn;
  logic              par;
  logic              in_range;
  logic [LANE_W-1:0] flip;

  always_comb begin
    recalc   = ecc_gen(data_i);
    syn      = recalc[HAM_W-1:0] ^ chk_i[HAM_W-1:0];
    par      = ^{data_i, chk_i};
    in_range = (int'(syn) <= CW_W);
    flip     = '0;
    for (int i = 0; i < LANE_W; i++)
      if (syn == HAM_W'(data_pos(i))) flip[i] = 1'b1;
  end

  assign sb_o   = en_i & par & in_range;
  assign db_o   = en_i & ((~par & (syn != '0)) | (par & ~in_range));
  assign data_o = sb_o ? (data_i ^ flip) : data_i;
endmodule

// File: rtl/lram_bank_log.sv
module lram_bank_log #(
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic              clr_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              sts_o,
  output logic              ovf_o,
  output logic [LINE_W-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_o  <= 1'b0;
      ovf_o  <= 1'b0;
      line_o <= '0;
    end else if (err_i) begin
      if (sts_o && !clr_i) begin
        ovf_o <= 1'b1;
      end else begin
        // first error, or error racing a clear: new error wins
        sts_o  <= 1'b1;
        ovf_o  <= 1'b0;
        line_o <= line_i;
      end
    end else if (clr_i) begin
      sts_o  <= 1'b0;
      ovf_o  <= 1'b0;
      line_o <= '0;
    end
  end
endmodule

// File: rtl/lram_ecc_regs.sv
module lram_ecc_regs #(
  parameter int NBANK  = 4,
  parameter int LINE_W = 16,
  parameter int RA_W   = 3
) (
  input  logic                    reg_we_i,
  input  logic [RA_W-1:0]         reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  input  logic [NBANK-1:0]        sts_i,
  input  logic [NBANK-1:0]        ovf_i,
  input  logic [NBANK*LINE_W-1:0] line_i,
  output logic [31:0]             reg_rdata_o,
  output logic [NBANK-1:0]        clr_o,
  output logic                    irq_o
);
  localparam logic [RA_W-1:0] A_STS = RA_W'(0);
  localparam logic [RA_W-1:0] A_OVF = RA_W'(1);
  localparam logic [RA_W-1:0] A_CLR = RA_W'(2);
  localparam int              A_LN0 = 4;

  assign clr_o = (reg_we_i && reg_addr_i == A_CLR) ? reg_wdata_i[NBANK-1:0] : '0;
  assign irq_o = |{sts_i, ovf_i};

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_STS) begin
      for (int n = 0; n < NBANK; n++) reg_rdata_o[8*n] = sts_i[n];
    end else if (reg_addr_i == A_OVF) begin
      reg_rdata_o[NBANK-1:0] = ovf_i;
    end else begin
      for (int n = 0; n < NBANK; n++)
        if (reg_addr_i == RA_W'(A_LN0 + n))
          reg_rdata_o[LINE_W-1:0] = line_i[n*LINE_W +: LINE_W];
    end
  end
endmodule

// File: rtl/lram_ecc_mon.sv
module lram_ecc_mon
  import lram_ecc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW    = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_valid_i,
  input  logic [NBANK-1:0]        rd_bank_en_i,
  input  logic [AW-1:0]           rd_addr_i,
  input  logic [NBANK*LANE_W-1:0] rd_data_i,
  input  logic [NBANK*CHK_W-1:0]  rd_chk_i,
  output logic [NBANK*LANE_W-1:0] rd_data_o,
  output logic                    fatal_o,
  input  logic                    reg_we_i,
  input  logic [2:0]              reg_addr_i,
  input  logic [31:0]             reg_wdata_i,
  output logic [31:0]             reg_rdata_o,
  output logic                    irq_o
);
  localparam int DATA_W = NBANK * LANE_W;
  localparam int OFS_W  = $clog2(DATA_W / 8);
  localparam int LINE_W = AW - OFS_W;

  logic [NBANK-1:0]        bank_sb;
  logic [NBANK-1:0]        bank_db;
  logic [NBANK-1:0]        bank_err;
  logic [NBANK-1:0]        bank_clr;
  logic [NBANK-1:0]        bank_sts;
  logic [NBANK-1:0]        bank_ovf;
  logic [NBANK*LINE_W-1:0] bank_line;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lram_secded_dec u_dec (
      .en_i   (rd_bank_en_i[b]),
      .data_i (rd_data_i[b*LANE_W +: LANE_W]),
      .chk_i  (rd_chk_i[b*CHK_W +: CHK_W]),
      .data_o (rd_data_o[b*LANE_W +: LANE_W]),
      .sb_o   (bank_sb[b]),
      .db_o   (bank_db[b])
    );

    assign bank_err[b] = rd_valid_i & bank_sb[b];

    lram_bank_log #(.LINE_W(LINE_W)) u_log (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .err_i  (bank_err[b]),
      .clr_i  (bank_clr[b]),
      .line_i (rd_addr_i[AW-1:OFS_W]),
      .sts_o  (bank_sts[b]),
      .ovf_o  (bank_ovf[b]),
      .line_o (bank_line[b*LINE_W +: LINE_W])
    );
  end

  assign fatal_o = rd_valid_i & (|bank_db);

  lram_ecc_regs #(.NBANK(NBANK), .LINE_W(LINE_W), .RA_W(3)) u_regs (
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .sts_i       (bank_sts),
    .ovf_i       (bank_ovf),
    .line_i      (bank_line),
    .reg_rdata_o (reg_rdata_o),
    .clr_o       (bank_clr),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/lram_ecc_mon_chk.sv
module lram_ecc_mon_chk #(
  parameter int NBANK  = 4,
  parameter int LINE_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    rd_valid_i,
  input logic                    fatal_o,
  input logic                    irq_o,
  input logic [NBANK-1:0]        bank_err,
  input logic [NBANK-1:0]        bank_clr,
  input logic [NBANK-1:0]        bank_sts,
  input logic [NBANK-1:0]        bank_ovf,
  input logic [NBANK*LINE_W-1:0] bank_line
);
  assert_fatal_needs_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> rd_valid_i);

  assert_irq_after_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rd_valid_i));

  for (genvar n = 0; n < NBANK; n++) begin : g_chk
    assert_line_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_sts[n] && !bank_clr[n]) |=> $stable(bank_line[n*LINE_W +: LINE_W]));

    assert_ovf_needs_sts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bank_ovf[n]) |-> $past(bank_sts[n]));

    assert_clear_wipes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_clr[n] && !bank_err[n]) |=> (!bank_sts[n] && !bank_ovf[n]));

    assert_err_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_clr[n] && bank_err[n]) |=> (bank_sts[n] && !bank_ovf[n]));
  end
endmodule

bind lram_ecc_mon lram_ecc_mon_chk #(.NBANK(NBANK), .LINE_W(LINE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_valid_i (rd_valid_i),
  .fatal_o    (fatal_o),
  .irq_o      (irq_o),
  .bank_err   (bank_err),
  .bank_clr   (bank_clr),
  .bank_sts   (bank_sts),
  .bank_ovf   (bank_ovf),
  .bank_line  (bank_line)
);

// File: tb/lram_ecc_mon_bench.sv
`timescale 1ns/100ps
module lram_ecc_mon_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rd_valid_i = 1'b0;
  logic [3:0]   rd_bank_en_i = '0;
  logic [19:0]  rd_addr_i = '0;
  logic [127:0] rd_data_i = '0;
  logic [27:0]  rd_chk_i = '0;
  logic [127:0] rd_data_o;
  logic         fatal_o;
  logic         reg_we_i = 1'b0;
  logic [2:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic         irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  lram_ecc_mon u_lram_ecc_mon (.*);

  // [15:12] lane enables, [11:10] bank, [9:8] kind (0 none,1 single,2 double), [7:0] bit (0-31 data, 32-38 check)
  localparam logic [15:0] VEC [16] = '{
    16'hF000, 16'hF100, 16'hF51F, 16'hF911, 16'hFD05, 16'hF520, 16'hF926, 16'hFD23,
    16'hF203, 16'hFE1F, 16'hF625, 16'h5504, 16'h2509, 16'hA207, 16'h1114, 16'h8E00
  };

  logic [127:0] orig_d, raw_d;
  logic [27:0]  raw_c;

  function automatic logic [6:0] enc(input logic [31:0] d);
    logic [38:1] cw;
    logic [6:0]  c;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= 38; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        cw[p] = d[k];
        k++;
      end
    c = '0;
    for (int j = 0; j < 6; j++)
      for (int p = 1; p <= 38; p++)
        if (((p >> j) & 1) == 1) c[j] = c[j] ^ cw[p];
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic flip(input int bk, input int idx);
    if (idx < 32) raw_d[bk*32 + idx] = ~raw_d[bk*32 + idx];
    else raw_c[bk*7 + idx - 32] = ~raw_c[bk*7 + idx - 32];
  endtask

  // drives a read with an injected fault; caller is at a negedge
  task automatic set_read(input logic [3:0] en, input int bk, input int kind, input int idx,
                          input logic [19:0] addr, input int seed);
    for (int b = 0; b < 4; b++) begin
      orig_d[b*32 +: 32] = (32'h9E3779B9 * 32'(seed + 1)) ^ {4{8'(b * 37 + 1)}};
      raw_c[b*7 +: 7]    = enc(orig_d[b*32 +: 32]);
    end
    raw_d = orig_d;
    if (kind != 0) flip(bk, idx);
    if (kind == 2) flip(bk, (idx + 1) % 39);
    rd_bank_en_i = en;
    rd_addr_i    = addr;
    rd_data_i    = raw_d;
    rd_chk_i     = raw_c;
    rd_valid_i   = 1'b1;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1;
    reg_addr_i = a;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic single_read(input int bk, input logic [19:0] addr, input int seed);
    @(negedge clk_i);
    set_read(4'hF, bk, 1, 3, addr, seed);
    @(negedge clk_i);
    rd_valid_i = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [3:0]  en;
    int bk, kind, idx;
    logic [19:0] addr;
    logic        en_b;
    logic [127:0] exp_d;

    repeat (3) @(negedge clk_i);
    // R10: reset state
    #1 check("R10 irq", 128'(irq_o), 128'd0);
    rst_ni = 1'b1;
    reg_rd(3'd0, v); check("R10 status", 128'(v), 128'd0);
    reg_rd(3'd1, v); check("R10 overflow", 128'(v), 128'd0);
    for (int n = 0; n < 4; n++) begin
      reg_rd(3'(4 + n), v); check("R10 line", 128'(v), 128'd0);
    end

    // vector table: R1 R2 R3 R4 R8 R9
    for (int k = 0; k < 16; k++) begin
      en   = VEC[k][15:12];
      bk   = int'(VEC[k][11:10]);
      kind = int'(VEC[k][9:8]);
      idx  = int'(VEC[k][7:0]);
      addr = 20'(k * 32'h1357 + 32'hA);
      en_b = en[bk];
      @(negedge clk_i);
      set_read(en, bk, kind, idx, addr, k);
      exp_d = orig_d;
      if (kind != 0 && (kind == 2 || !en_b))
        exp_d[bk*32 +: 32] = raw_d[bk*32 +: 32];
      #1;
      check("R1 R2 R9 data", rd_data_o, exp_d);
      check("R3 R9 fatal", 128'(fatal_o), 128'(kind == 2 && en_b));
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      #1 check("R8 irq", 128'(irq_o), 128'(kind == 1 && en_b));
      reg_rd(3'd0, v);
      check("R4 status", 128'(v), (kind == 1 && en_b) ? (128'd1 << (8 * bk)) : 128'd0);
      if (kind == 1 && en_b) begin
        reg_rd(3'(4 + bk), v);
        check("R4 line", 128'(v), 128'(addr[19:4]));
      end
      reg_wr(3'd2, 32'hF);
      #1 check("R6 irq after clear", 128'(irq_o), 128'd0);
    end

    // R5: overflow keeps first address
    single_read(1, 20'h12345, 1);
    single_read(1, 20'h6789A, 2);
    reg_rd(3'd1, v); check("R5 overflow", 128'(v), 128'h2);
    reg_rd(3'd0, v); check("R5 status", 128'(v), 128'h100);
    reg_rd(3'd5, v); check("R5 line kept", 128'(v), 128'h1234);
    #0 check("R8 irq set", 128'(irq_o), 128'd1);

    // R6: clear only bank 1
    single_read(2, 20'hABCDE, 3);
    reg_wr(3'd2, 32'h2);
    reg_rd(3'd0, v); check("R6 status", 128'(v), 128'h10000);
    reg_rd(3'd1, v); check("R6 overflow", 128'(v), 128'h0);
    reg_rd(3'd5, v); check("R6 line cleared", 128'(v), 128'h0);
    reg_rd(3'd6, v); check("R6 line untouched", 128'(v), 128'hABCD);
    reg_rd(3'd2, v); check("R6 clear reads 0", 128'(v), 128'h0);

    // R11: writes elsewhere ignored
    reg_wr(3'd0, 32'hFFFF_FFFF);
    reg_wr(3'd1, 32'hFFFF_FFFF);
    reg_wr(3'd6, 32'h0);
    reg_rd(3'd0, v); check("R11 status", 128'(v), 128'h10000);
    reg_rd(3'd1, v); check("R11 overflow", 128'(v), 128'h0);
    reg_rd(3'd6, v); check("R11 line", 128'(v), 128'hABCD);
    reg_rd(3'd3, v); check("R11 addr3", 128'(v), 128'h0);

    // R9: single error with valid low is ignored
    @(negedge clk_i);
    set_read(4'hF, 0, 1, 3, 20'h11110, 4);
    rd_valid_i = 1'b0;
    #1 check("R9 no fatal", 128'(fatal_o), 128'd0);
    reg_rd(3'd0, v); check("R9 status", 128'(v), 128'h10000);

    // R7: clear and new error collide in bank 2 with overflow pending
    single_read(2, 20'h22220, 5);
    reg_rd(3'd1, v); check("R7 overflow before", 128'(v), 128'h4);
    @(negedge clk_i);
    set_read(4'hF, 2, 1, 3, 20'h55550, 6);
    reg_we_i = 1'b1; reg_addr_i = 3'd2; reg_wdata_i = 32'h4;
    @(negedge clk_i);
    rd_valid_i = 1'b0; reg_we_i = 1'b0;
    reg_rd(3'd0, v); check("R7 status", 128'(v), 128'h10000);
    reg_rd(3'd1, v); check("R7 overflow", 128'(v), 128'h0);
    reg_rd(3'd6, v); check("R7 new line", 128'(v), 128'h5555);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule